// File: doc/BRIEF.md
# Uncorrectable Error Header Log Queue

This block holds the log state for uncorrectable errors: a pointer to the status bit of the first logged error, a four-dword header log, a four-dword prefix log with its own "prefix logged" flag, and the uncorrectable status register. An error record arrives in one cycle. It carries one status bit, a header-valid flag with four header dwords, and a prefix-present flag with four prefix dwords. Software clears status bits by writing ones to the status register through a separate write port.

When multiple header recording is enabled and the error at the pointer is still set, a new record is not logged. It waits in a small FIFO instead. When software clears the pointed-to status bit, the oldest waiting record moves into the log, and the status bits of all waiting records are set again. If the FIFO is full, the record is dropped and a one-cycle overflow pulse tells the surrounding logic to raise a header-log-overflow correctable error. The FIFO depth is the parameter `QDEPTH`, clamped to at most 32.

Top module: `uehl_top`

## Requirements
- R1: After synchronous reset, `unc_status`, `fep`, `hdr_log`, `pfx_log`, `pfx_logged` and `log_overflow` are all zero, and the FIFO is empty.
- R2: A record counts only when `rec_status` has exactly one bit set. Such a record sets that bit in `unc_status` in the next cycle. A record with zero bits or several bits set changes no output.
- R3: When a record is logged, `fep` takes the index of its status bit. If the header-valid flag is set, dword k of the header (input bits [32k+31:32k]) is stored byte-reversed in `hdr_log[32k+31:32k]`. If the flag is clear, `hdr_log` becomes zero.
- R4: When a record is logged, the prefix is stored byte-reversed in the same dword layout as the header, and `pfx_logged` is set, only if both the record's prefix-present flag and `pfx_cap` are 1. Otherwise `pfx_log` and `pfx_logged` become zero.
- R5: If `mhr_en` is 1 and `unc_status[fep]` is set, a valid record is queued and the log registers keep their values.
- R6: If a record must be queued and the FIFO already holds `QDEPTH` entries, the record is discarded and its status bit is still set. `log_overflow` is 1 for exactly the next cycle only.
- R7: If a status write clears `unc_status[fep]` and either `mhr_en` is 0 or the FIFO is empty, `fep`, `pfx_logged`, `hdr_log` and `pfx_log` are cleared to zero.
- R8: If a status write clears `unc_status[fep]` while `mhr_en` is 1 and the FIFO holds entries, the status bits of all queued entries are set again. The oldest entry then leaves the FIFO and is loaded into the log, following the rules of R3 and R4. Entries leave in the order they arrived.
- R9: If `unc_status[fep]` is still set after a status write and `mhr_en` is 1, the status bits of queued entries are set again, so a write that clears only queued bits has no effect.
- R10: While `mhr_en` is 0 the FIFO is emptied. A later clear of the first-error bit then clears the log instead of loading a stale entry.
- R11: When a status write and a record arrive in the same cycle, the write is applied first, and the record is then handled against the resulting state.
- R12: The FIFO occupancy never exceeds `QDEPTH`, and an entry is never taken from an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mhr_en | input | 1 | Multiple header recording enable |
| pfx_cap | input | 1 | Device supports end-to-end prefixes |
| rec_valid | input | 1 | Error record strobe |
| rec_status | input | 32 | Status bit of the record (one-hot) |
| rec_hdr_valid | input | 1 | Header dwords are valid |
| rec_hdr | input | 128 | Header dwords, dword k in bits [32k+31:32k] |
| rec_pfx_present | input | 1 | Record carries a prefix |
| rec_pfx | input | 128 | Prefix dwords, same layout as the header |
| w1c_valid | input | 1 | Status register write strobe |
| w1c_data | input | 32 | Write-one-to-clear mask |
| fep | output | 5 | First-error pointer |
| pfx_logged | output | 1 | Prefix log holds a valid prefix |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| unc_status | output | 32 | Uncorrectable status register |
| log_overflow | output | 1 | One-cycle pulse: a record was dropped on a full FIFO |

## Verification
The hardest state to reach is a status write and a record in the same cycle, where the write clears the first-error bit and so decides whether the record is logged or queued. The bench logs one error and then issues, in a single cycle, a write that clears that bit together with a new record. With the correct ordering the new record lands in the log. With the wrong ordering it would be queued behind a log that has just been cleared. A full FIFO is reached by logging one error and then sending more records than `QDEPTH`. Draining the FIFO then shows both the arrival order and that the dropped record never appears in the log.

// File: rtl/uehl_pkg.sv
package uehl_pkg;
    localparam int STAT_W       = 32;
    localparam int IDX_W        = $clog2(STAT_W);
    localparam int DW_W         = 32;
    localparam int LOG_DW       = 4;
    localparam int LOG_W        = DW_W * LOG_DW;
    localparam int QDEPTH_LIMIT = 32;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hdr_ok;
        logic [LOG_W-1:0] hdr;
        logic             pfx_ok;
        logic [LOG_W-1:0] pfx;
    } err_rec_t;

    function automatic logic single_bit(input logic [STAT_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [IDX_W-1:0] bit_pos(input logic [STAT_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < STAT_W; i++)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    function automatic logic [LOG_W-1:0] dword_bswap(input logic [LOG_W-1:0] v);
        logic [LOG_W-1:0] r;
        for (int k = 0; k < LOG_DW; k++)
            for (int b = 0; b < DW_W/8; b++)
                r[k*DW_W + b*8 +: 8] = v[k*DW_W + (DW_W/8-1-b)*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/uehl_fifo.sv
module uehl_fifo
    import uehl_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                push,
    input  logic                pop,
    input  err_rec_t            din,
    output err_rec_t            head,
    output logic [STAT_W-1:0]   occ_mask,
    output logic [CNT_W-1:0]    count,
    output logic                empty,
    output logic                full
);
    err_rec_t         slot [DEPTH];
    logic [CNT_W-1:0] wr_pos;

    assign empty  = (count == '0);
    assign full   = (count == CNT_W'(DEPTH));
    assign head   = slot[0];
    assign wr_pos = pop ? count - 1'b1 : count;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            err_rec_t shifted;
            if (g < DEPTH - 1) begin : g_mid
                assign shifted = slot[g+1];
            end else begin : g_end
                assign shifted = slot[g];
            end
            always_ff @(posedge clk) begin
                if (push && wr_pos == CNT_W'(g))
                    slot[g] <= din;
                else if (pop)
                    slot[g] <= shifted;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush)
            count <= '0;
        else
            count <= count + CNT_W'(push) - CNT_W'(pop);
    end

    always_comb begin
        occ_mask = '0;
        for (int i = 0; i < DEPTH; i++)
            if (CNT_W'(i) < count) occ_mask[slot[i].idx] = 1'b1;
    end
endmodule

// File: rtl/uehl_logreg.sv
module uehl_logreg
    import uehl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  err_rec_t          src,
    input  logic              pfx_cap,
    output logic [IDX_W-1:0]  fep,
    output logic              pfx_logged,
    output logic [LOG_W-1:0]  hdr_log,
    output logic [LOG_W-1:0]  pfx_log
);
    logic keep_pfx;
    assign keep_pfx = src.pfx_ok && pfx_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            fep        <= '0;
            pfx_logged <= 1'b0;
            hdr_log    <= '0;
            pfx_log    <= '0;
        end else if (load) begin
            fep        <= src.idx;
            pfx_logged <= keep_pfx;
            hdr_log    <= src.hdr_ok ? dword_bswap(src.hdr) : '0;
            pfx_log    <= keep_pfx   ? dword_bswap(src.pfx) : '0;
        end else if (clear) begin
            fep        <= '0;
            pfx_logged <= 1'b0;
            hdr_log    <= '0;
            pfx_log    <= '0;
        end
    end
endmodule

// File: rtl/uehl_top.sv
module uehl_top
    import uehl_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mhr_en,
    input  logic              pfx_cap,
    input  logic              rec_valid,
    input  logic [31:0]       rec_status,
    input  logic              rec_hdr_valid,
    input  logic [127:0]      rec_hdr,
    input  logic              rec_pfx_present,
    input  logic [127:0]      rec_pfx,
    input  logic              w1c_valid,
    input  logic [31:0]       w1c_data,
    output logic [4:0]        fep,
    output logic              pfx_logged,
    output logic [127:0]      hdr_log,
    output logic [127:0]      pfx_log,
    output logic [31:0]       unc_status,
    output logic              log_overflow
);
    localparam int DEPTH = (QDEPTH > QDEPTH_LIMIT) ? QDEPTH_LIMIT :
                           (QDEPTH < 1) ? 1 : QDEPTH;
    localparam int CNT_W = $clog2(DEPTH + 1);

    err_rec_t          in_rec, fifo_head, log_src;
    logic [STAT_W-1:0] occ_mask, status_w, status_nxt;
    logic [CNT_W-1:0]  q_count;
    logic              q_empty, q_full;
    logic              do_pop, do_push, do_clr, log_rec, ovf_nxt, rec_ok;
    logic [IDX_W-1:0]  mid_fep;

    assign in_rec.idx    = bit_pos(rec_status);
    assign in_rec.hdr_ok = rec_hdr_valid;
    assign in_rec.hdr    = rec_hdr;
    assign in_rec.pfx_ok = rec_pfx_present;
    assign in_rec.pfx    = rec_pfx;
    assign rec_ok        = rec_valid && single_bit(rec_status);

    // Write stage first, then the record sees the post-write state.
    always_comb begin
        status_w = unc_status;
        do_pop   = 1'b0;
        do_clr   = 1'b0;
        if (w1c_valid) begin
            status_w = unc_status & ~w1c_data;
            if (!status_w[fep]) begin
                if (!mhr_en || q_empty) begin
                    do_clr = 1'b1;
                end else begin
                    status_w = status_w | occ_mask;
                    do_pop   = 1'b1;
                end
            end else if (mhr_en) begin
                status_w = status_w | occ_mask;
            end
        end
        mid_fep = do_pop ? fifo_head.idx : (do_clr ? '0 : fep);

        status_nxt = status_w;
        do_push    = 1'b0;
        log_rec    = 1'b0;
        ovf_nxt    = 1'b0;
        if (rec_ok) begin
            status_nxt = status_w | rec_status;
            if (mhr_en && status_w[mid_fep]) begin
                if (q_full && !do_pop) ovf_nxt = 1'b1;
                else                   do_push = 1'b1;
            end else begin
                log_rec = 1'b1;
            end
        end
    end

    assign log_src = do_pop ? fifo_head : in_rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            unc_status   <= '0;
            log_overflow <= 1'b0;
        end else begin
            unc_status   <= status_nxt;
            log_overflow <= ovf_nxt;
        end
    end

    uehl_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (!mhr_en),
        .push     (do_push),
        .pop      (do_pop),
        .din      (in_rec),
        .head     (fifo_head),
        .occ_mask (occ_mask),
        .count    (q_count),
        .empty    (q_empty),
        .full     (q_full)
    );

    uehl_logreg u_log (
        .clk        (clk),
        .rst        (rst),
        .load       (do_pop || log_rec),
        .clear      (do_clr),
        .src        (log_src),
        .pfx_cap    (pfx_cap),
        .fep        (fep),
        .pfx_logged (pfx_logged),
        .hdr_log    (hdr_log),
        .pfx_log    (pfx_log)
    );
endmodule

// File: rtl/uehl_chk.sv
module uehl_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             mhr_en,
    input logic             rec_valid,
    input logic [31:0]      rec_status,
    input logic             w1c_valid,
    input logic [31:0]      unc_status,
    input logic [4:0]       fep,
    input logic             log_overflow,
    input logic             do_pop,
    input logic             log_rec,
    input logic             q_empty,
    input logic [CNT_W-1:0] q_count
);
    p_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));

    p_no_pop_empty_r12: assert property (@(posedge clk) disable iff (rst)
        do_pop |-> !q_empty);

    p_flush_r10: assert property (@(posedge clk) disable iff (rst)
        !mhr_en |=> q_count == '0);

    p_one_load_r11: assert property (@(posedge clk) disable iff (rst)
        !(do_pop && log_rec));

    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (rst)
        !rec_valid |=> !log_overflow);

    p_rec_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && $countones(rec_status) == 1) |=> (unc_status & $past(rec_status)) != '0);

    p_bad_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && $countones(rec_status) != 1 && !w1c_valid) |=> $stable(unc_status) && $stable(fep));

    p_pop_sets_first_r8: assert property (@(posedge clk) disable iff (rst)
        do_pop |=> unc_status[fep]);
endmodule

bind uehl_top uehl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mhr_en       (mhr_en),
    .rec_valid    (rec_valid),
    .rec_status   (rec_status),
    .w1c_valid    (w1c_valid),
    .unc_status   (unc_status),
    .fep          (fep),
    .log_overflow (log_overflow),
    .do_pop       (do_pop),
    .log_rec      (log_rec),
    .q_empty      (q_empty),
    .q_count      (q_count)
);

// File: tb/sim_uehl_top.sv
`timescale 1ns/1ps
module sim_uehl_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mhr_en = 1'b0, pfx_cap = 1'b0;
    logic         rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_present = 1'b0;
    logic [31:0]  rec_status = '0;
    logic [127:0] rec_hdr = '0, rec_pfx = '0;
    logic         w1c_valid = 1'b0;
    logic [31:0]  w1c_data = '0;
    logic [4:0]   fep;
    logic         pfx_logged, log_overflow;
    logic [127:0] hdr_log, pfx_log;
    logic [31:0]  unc_status;

    int n_cmp = 0, n_mis = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uehl_top #(.QDEPTH(4)) u0 (.*);

    typedef struct packed {
        logic [4:0] idx;
        logic       hv;
        logic       pp;
        logic       cap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd3,  1'b1, 1'b0, 1'b0},
        '{5'd7,  1'b0, 1'b1, 1'b1},
        '{5'd10, 1'b1, 1'b1, 1'b1},
        '{5'd15, 1'b1, 1'b1, 1'b0},
        '{5'd20, 1'b0, 1'b0, 1'b1},
        '{5'd26, 1'b1, 1'b0, 1'b1},
        '{5'd31, 1'b0, 1'b1, 1'b1},
        '{5'd0,  1'b1, 1'b1, 1'b1}
    };

    function automatic logic [127:0] mk_log(input int idx, input logic [7:0] salt);
        logic [127:0] r;
        for (int k = 0; k < 4; k++)
            r[k*32 +: 32] = {8'(8'h80 + k), 8'(idx), salt, 8'(idx*7 + k)};
        return r;
    endfunction

    function automatic logic [127:0] rev_bytes(input logic [127:0] v);
        logic [127:0] r;
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 4; b++)
                r[k*32 + b*8 +: 8] = v[k*32 + (3-b)*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string what, input logic [127:0] got, input logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_mis++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic set_rec(input int idx, input logic hv, input logic pp);
        rec_valid       = 1'b1;
        rec_status      = 32'h1 << idx;
        rec_hdr_valid   = hv;
        rec_hdr         = mk_log(idx, 8'hC3);
        rec_pfx_present = pp;
        rec_pfx         = mk_log(idx, 8'h5A);
    endtask

    task automatic step();
        @(negedge clk);
        rec_valid  = 1'b0;
        rec_status = '0;
        w1c_valid  = 1'b0;
        w1c_data   = '0;
    endtask

    task automatic send_rec(input int idx, input logic hv, input logic pp);
        set_rec(idx, hv, pp);
        step();
    endtask

    task automatic send_w1c(input logic [31:0] m);
        w1c_valid = 1'b1;
        w1c_data  = m;
        step();
    endtask

    task automatic cleanup();
        mhr_en = 1'b0;
        step();
        send_w1c(32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_mis++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 status", unc_status, 0);
        chk("R1 fep", fep, 0);
        chk("R1 hdr", hdr_log, 0);
        chk("R1 pfx", {pfx_log, pfx_logged, log_overflow}, 0);

        // R2 malformed records are ignored
        mhr_en = 1'b1;
        rec_valid = 1'b1; rec_status = 32'h0; rec_hdr_valid = 1'b1; step();
        chk("R2 zero bits status", unc_status, 0);
        rec_valid = 1'b1; rec_status = 32'h0000_0006; rec_hdr_valid = 1'b1; step();
        chk("R2 two bits status", unc_status, 0);
        chk("R2 two bits hdr", hdr_log, 0);

        // R3 R4 table walk with recording disabled
        mhr_en = 1'b0;
        foreach (VECS[i]) begin
            pfx_cap = VECS[i].cap;
            send_rec(VECS[i].idx, VECS[i].hv, VECS[i].pp);
            chk("R2 status bit", unc_status, 32'h1 << VECS[i].idx);
            chk("R3 fep", fep, VECS[i].idx);
            chk("R3 hdr", hdr_log, VECS[i].hv ? rev_bytes(mk_log(VECS[i].idx, 8'hC3)) : 128'h0);
            chk("R4 pfx", pfx_log, (VECS[i].pp && VECS[i].cap) ?
                rev_bytes(mk_log(VECS[i].idx, 8'h5A)) : 128'h0);
            chk("R4 pfx flag", pfx_logged, VECS[i].pp && VECS[i].cap);
            send_w1c(32'hFFFF_FFFF);
            chk("R7 cleared", {hdr_log, pfx_log, fep, pfx_logged}, 0);
        end

        // R5 R9 R8 R7 queueing and draining
        mhr_en = 1'b1; pfx_cap = 1'b0;
        send_rec(4, 1'b1, 1'b0);
        send_rec(9, 1'b1, 1'b0);
        send_rec(12, 1'b1, 1'b0);
        chk("R5 fep kept", fep, 4);
        chk("R5 hdr kept", hdr_log, rev_bytes(mk_log(4, 8'hC3)));
        chk("R5 status", unc_status, 32'h0000_1210);
        send_w1c(32'h1 << 9);
        chk("R9 queued bit restored", unc_status, 32'h0000_1210);
        chk("R9 fep", fep, 4);
        send_w1c(32'h1 << 4);
        chk("R8 pop fep", fep, 9);
        chk("R8 pop hdr", hdr_log, rev_bytes(mk_log(9, 8'hC3)));
        chk("R8 status", unc_status, 32'h0000_1200);
        send_w1c(32'h1 << 9);
        chk("R8 order fep", fep, 12);
        send_w1c(32'h1 << 12);
        chk("R7 empty clear fep", fep, 0);
        chk("R7 empty clear hdr", hdr_log, 0);
        chk("R7 status", unc_status, 0);

        // R6 overflow and order after full
        send_rec(1, 1'b1, 1'b0);
        send_rec(2, 1'b1, 1'b0);
        send_rec(3, 1'b1, 1'b0);
        send_rec(5, 1'b1, 1'b0);
        send_rec(6, 1'b1, 1'b0);
        chk("R6 no overflow yet", log_overflow, 0);
        send_rec(7, 1'b1, 1'b0);
        chk("R6 overflow pulse", log_overflow, 1);
        chk("R6 dropped bit set", unc_status, 32'h0000_00EE);
        step();
        chk("R6 pulse ends", log_overflow, 0);
        send_w1c(32'h1 << 1); chk("R8 fifo order 2", fep, 2);
        send_w1c(32'h1 << 2); chk("R8 fifo order 3", fep, 3);
        send_w1c(32'h1 << 3); chk("R8 fifo order 5", fep, 5);
        send_w1c(32'h1 << 5); chk("R8 fifo order 6", fep, 6);
        send_w1c(32'h1 << 6);
        chk("R6 dropped not logged", fep, 0);
        chk("R6 leftover status", unc_status, 32'h1 << 7);
        cleanup();

        // R10 flush
        mhr_en = 1'b1;
        send_rec(1, 1'b1, 1'b0);
        send_rec(2, 1'b1, 1'b0);
        mhr_en = 1'b0; step();
        mhr_en = 1'b1;
        send_w1c(32'h1 << 1);
        chk("R10 flushed fep", fep, 0);
        chk("R10 flushed hdr", hdr_log, 0);
        chk("R10 status", unc_status, 32'h1 << 2);
        cleanup();

        // R11 write and record together
        mhr_en = 1'b1;
        send_rec(3, 1'b1, 1'b0);
        set_rec(8, 1'b1, 1'b0);
        w1c_valid = 1'b1; w1c_data = 32'h1 << 3;
        step();
        chk("R11 fep", fep, 8);
        chk("R11 hdr", hdr_log, rev_bytes(mk_log(8, 8'hC3)));
        chk("R11 status", unc_status, 32'h1 << 8);
        rec_valid = 1'b1; rec_status = 32'h0000_0300; step();
        chk("R2 multi ignored status", unc_status, 32'h1 << 8);
        chk("R2 multi ignored fep", fep, 8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule